// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It walks a two-level page table that lives in physical memory. A request carries the logical address, an access kind (read or write) and a privilege flag. The walker samples a table-base value together with the request. It then issues one read for the first-level entry and one read for the second-level entry. On success it writes the updated second-level entry back. At the end it reports a physical address and a two-bit fault code.

Pages are 8 KB. The low 13 address bits are the page offset and pass straight through to the physical address. The 19-bit page number splits into a 10-bit first-level index and a 9-bit second-level index. Every pointer held in either table level is a physical address.

Each entry is 32 bits. In a second-level entry, bit 0 is valid, bit 1 is referenced, bit 2 is dirty, bit 3 allows writes and bit 4 allows user access. Bits 31:13 hold the frame number. In a first-level entry, bit 0 is valid and the bits above bit 10 locate the second-level table. The walker handles one request at a time. Memory is reached through a request/acknowledge port: the request is held until an acknowledge arrives, and read data is valid in the acknowledge cycle.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and mem_req is 0.
- R2: The first memory read goes to (ptbr with bits 11:0 cleared) + 4 × vaddr[31:22]. The low 12 bits of ptbr are ignored.
- R3: If bit 0 of the first-level entry is 0, the walk ends with fault code 1 after that single read. No second-level read and no write are issued.
- R4: The second read goes to (first-level entry with bits 10:0 cleared) + 4 × vaddr[21:13]. Bits 10:1 of the first-level entry have no effect on the address.
- R5: If bit 0 of the second-level entry is 0, the fault code is 2 whatever the other entry bits hold, and no write is issued.
- R6: A valid second-level entry gives fault code 3, with no write, when a write request meets bit 3 = 0 or a user request meets bit 4 = 0.
- R7: On success the fault code is 0 and paddr = {entry[31:13], vaddr[12:0]}.
- R8: On success the walker writes the entry back to the second-level address. The written value has bit 1 set, and also bit 2 set for a write request. All other bits are unchanged.
- R9: done is high for exactly one cycle per request. When the fault code is nonzero, paddr is 0 during done.
- R10: mem_req stays high with a stable address and write flag until mem_ack. req_ready is low from acceptance until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Logical address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user privilege |
| ptbr | input | 32 | Physical base of the first-level table |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | 0 ok, 1 first level invalid, 2 second level invalid, 3 protection |
| paddr | output | 32 | Translated physical address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge, read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
Several properties are checked on every cycle:
- the memory request is held with a stable address until acknowledged;
- the walker is busy whenever memory is requested;
- done lasts a single cycle;
- a faulting result carries a zero address;
- a successful result keeps the page offset and is always preceded by the write-back.

Other behaviour appears only in the bench's sweeps: the exact table addresses, the split between fault codes under every combination of entry flags, access kind and privilege, the frame concatenation, the merged write-back value, and the absence of a second read after an invalid first-level entry.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_L1_INV = 2'd1,
    FLT_L2_INV = 2'd2,
    FLT_PROT   = 2'd3
  } ptw_fault_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_L1   = 3'd1,
    ST_L2   = 3'd2,
    ST_WB   = 3'd3,
    ST_DONE = 3'd4
  } ptw_state_e;

  // entry flag positions (shared by both table levels where relevant)
  localparam int unsigned BIT_VALID   = 0;
  localparam int unsigned BIT_REF     = 1;
  localparam int unsigned BIT_DIRTY   = 2;
  localparam int unsigned BIT_WR_OK   = 3;
  localparam int unsigned BIT_USER_OK = 4;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PA_W     = 32,
  parameter int unsigned OFF_W    = 13,
  parameter int unsigned L1_W     = 10,
  parameter int unsigned L2_W     = 9,
  parameter int unsigned ENT_LOG2 = 2
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [PA_W-1:0]  ptbr,
  input  logic [PA_W-1:0]  l1_entry,
  output logic [PA_W-1:0]  l1_addr,
  output logic [PA_W-1:0]  l2_addr,
  output logic [OFF_W-1:0] offset
);
  localparam int unsigned L1_SPAN = L1_W + ENT_LOG2;
  localparam int unsigned L2_SPAN = L2_W + ENT_LOG2;

  // table base aligned to the table size, plus index scaled by entry size
  function automatic logic [PA_W-1:0] slot_addr(input logic [PA_W-1:0] base,
                                                input logic [PA_W-1:0] idx,
                                                input int unsigned     span);
    logic [PA_W-1:0] keep;
    keep = ~((PA_W'(1) << span) - PA_W'(1));
    return (base & keep) | (idx << ENT_LOG2);
  endfunction

  assign l1_addr = slot_addr(ptbr, PA_W'(vaddr[VA_W-1 -: L1_W]), L1_SPAN);
  assign l2_addr = slot_addr(l1_entry, PA_W'(vaddr[OFF_W +: L2_W]), L2_SPAN);
  assign offset  = vaddr[OFF_W-1:0];
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
#(
  parameter int unsigned PTE_W   = 32,
  parameter int unsigned FRAME_W = 19
) (
  input  logic [PTE_W-1:0]   pte,
  input  logic               is_write,
  input  logic               is_user,
  output ptw_fault_e         fault,
  output logic [FRAME_W-1:0] frame,
  output logic [PTE_W-1:0]   wb_data
);
  function automatic ptw_fault_e classify(input logic [PTE_W-1:0] e,
                                          input logic w, input logic u);
    if (!e[BIT_VALID]) return FLT_L2_INV;
    if ((w && !e[BIT_WR_OK]) || (u && !e[BIT_USER_OK])) return FLT_PROT;
    return FLT_NONE;
  endfunction

  function automatic logic [PTE_W-1:0] mark_used(input logic [PTE_W-1:0] e,
                                                 input logic w);
    logic [PTE_W-1:0] r;
    r = e;
    r[BIT_REF] = 1'b1;
    if (w) r[BIT_DIRTY] = 1'b1;
    return r;
  endfunction

  assign fault   = classify(pte, is_write, is_user);
  assign frame   = pte[PTE_W-1 -: FRAME_W];
  assign wb_data = mark_used(pte, is_write);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 13,
  parameter int unsigned L1_W  = 10,
  parameter int unsigned L2_W  = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  input  logic            req_user,
  input  logic [PA_W-1:0] ptbr,
  output logic            done,
  output logic [1:0]      fault,
  output logic [PA_W-1:0] paddr,
  output logic            mem_req,
  output logic            mem_we,
  output logic [PA_W-1:0] mem_addr,
  output logic [PA_W-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic [PA_W-1:0] mem_rdata
);
  localparam int unsigned PTE_W   = PA_W;
  localparam int unsigned FRAME_W = PA_W - OFF_W;

  ptw_state_e       state;
  logic [VA_W-1:0]  va_q;
  logic             wr_q, us_q;
  logic [PA_W-1:0]  ptbr_q, l1_q, l2_q, paddr_q;
  ptw_fault_e       fault_q;

  logic [PA_W-1:0]    l1_addr, l2_addr, wb_data, pte_in;
  logic [OFF_W-1:0]   offset;
  logic [FRAME_W-1:0] frame;
  ptw_fault_e         l2_fault;

  // named events
  logic accept, l1_resp, l1_invalid, l2_resp, wb_resp;
  assign accept     = req_valid && req_ready;
  assign l1_resp    = (state == ST_L1) && mem_ack;
  assign l1_invalid = l1_resp && !mem_rdata[BIT_VALID];
  assign l2_resp    = (state == ST_L2) && mem_ack;
  assign wb_resp    = (state == ST_WB) && mem_ack;

  ptw_addr_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .L1_W(L1_W), .L2_W(L2_W), .ENT_LOG2(2)
  ) u_addr (
    .vaddr(va_q), .ptbr(ptbr_q), .l1_entry(l1_q),
    .l1_addr(l1_addr), .l2_addr(l2_addr), .offset(offset)
  );

  assign pte_in = (state == ST_L2) ? mem_rdata : l2_q;

  ptw_pte_check #(.PTE_W(PTE_W), .FRAME_W(FRAME_W)) u_chk (
    .pte(pte_in), .is_write(wr_q), .is_user(us_q),
    .fault(l2_fault), .frame(frame), .wb_data(wb_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      us_q    <= 1'b0;
      ptbr_q  <= '0;
      l1_q    <= '0;
      l2_q    <= '0;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          va_q   <= req_vaddr;
          wr_q   <= req_write;
          us_q   <= req_user;
          ptbr_q <= ptbr;
          state  <= ST_L1;
        end
        ST_L1: if (l1_resp) begin
          l1_q <= mem_rdata;
          if (l1_invalid) begin
            fault_q <= FLT_L1_INV;
            paddr_q <= '0;
            state   <= ST_DONE;
          end else begin
            state <= ST_L2;
          end
        end
        ST_L2: if (l2_resp) begin
          l2_q    <= mem_rdata;
          fault_q <= l2_fault;
          if (l2_fault == FLT_NONE) begin
            paddr_q <= {frame, offset};
            state   <= ST_WB;
          end else begin
            paddr_q <= '0;
            state   <= ST_DONE;
          end
        end
        ST_WB:   if (wb_resp) state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign done      = (state == ST_DONE);
  assign fault     = fault_q;
  assign paddr     = paddr_q;
  assign mem_req   = (state == ST_L1) || (state == ST_L2) || (state == ST_WB);
  assign mem_we    = (state == ST_WB);
  assign mem_addr  = (state == ST_L1) ? l1_addr : l2_addr;
  assign mem_wdata = wb_data;

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_fault_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && (fault != 2'd0) |-> paddr == '0);
  assert_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && (fault == 2'd0) |-> paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);
  assert_wb_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && (fault == 2'd0) |-> $past(mem_we && mem_ack));
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0, ptbr = '0;
  logic        req_ready, done, mem_req, mem_we;
  logic [1:0]  fault;
  logic [31:0] paddr, mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, failures = 0;
  int lat = 0, cnt = 0;
  int nrd = 0, nwr = 0;
  logic [31:0] rd_addr0, rd_addr1, wr_addr, wr_data;
  logic [31:0] mem [logic [31:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user), .ptbr(ptbr),
    .done(done), .fault(fault), .paddr(paddr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model: acknowledges after lat idle cycles, driven at negedge
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      cnt = 0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
      end else cnt++;
    end
  end

  // transaction monitor
  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        nwr++; wr_addr = mem_addr; wr_data = mem_wdata;
      end else begin
        if (nrd == 0) rd_addr0 = mem_addr;
        if (nrd == 1) rd_addr1 = mem_addr;
        nrd++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_case(input logic [31:0] va, input bit wr, input bit us,
                          input logic [31:0] base, input logic [31:0] l1e,
                          input logic [31:0] l2e, input int latency);
    logic [31:0] l1a, l2a, exp_pa, exp_wb;
    int exp_f, busy_ready, waited;
    l1a = (base & 32'hFFFF_F000) + 32'(va[31:22]) * 4;
    l2a = (l1e & 32'hFFFF_F800) + 32'(va[21:13]) * 4;
    mem.delete();
    mem[l1a] = l1e;
    mem[l2a] = l2e;
    if (!l1e[0]) exp_f = 1;
    else if (!l2e[0]) exp_f = 2;
    else if ((wr && !l2e[3]) || (us && !l2e[4])) exp_f = 3;
    else exp_f = 0;
    exp_pa = (exp_f == 0) ? ((l2e & 32'hFFFF_E000) | (va & 32'h1FFF)) : 32'h0;
    exp_wb = l2e | 32'h2 | (wr ? 32'h4 : 32'h0);
    lat = latency; nrd = 0; nwr = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = us; ptbr = base;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ready = 0; waited = 0;
    while (!done && waited < 200) begin
      if (req_ready) busy_ready++;
      @(negedge clk);
      waited++;
    end
    chk(done == 1'b1, "R10", "walk completes", 32'(done), 32'h1);
    chk(busy_ready == 0, "R10", "ready low while busy", 32'(busy_ready), 32'h0);
    chk(fault == 2'(exp_f), exp_f == 1 ? "R3" : exp_f == 2 ? "R5" : exp_f == 3 ? "R6" : "R7",
        "fault code", 32'(fault), 32'(exp_f));
    chk(paddr == exp_pa, exp_f == 0 ? "R7" : "R9", "paddr", paddr, exp_pa);
    chk(rd_addr0 == l1a, "R2", "first-level address", rd_addr0, l1a);
    chk(nrd == ((exp_f == 1) ? 1 : 2), "R3", "read count", 32'(nrd), (exp_f == 1) ? 32'd1 : 32'd2);
    if (exp_f != 1) chk(rd_addr1 == l2a, "R4", "second-level address", rd_addr1, l2a);
    chk(nwr == ((exp_f == 0) ? 1 : 0), "R8", "write-back count", 32'(nwr), (exp_f == 0) ? 32'd1 : 32'd0);
    if (exp_f == 0) begin
      chk(wr_addr == l2a, "R8", "write-back address", wr_addr, l2a);
      chk(wr_data == exp_wb, "R8", "write-back data", wr_data, exp_wb);
      chk(mem[l2a] == exp_wb, "R8", "stored entry", mem[l2a], exp_wb);
    end else begin
      chk(mem[l2a] == l2e, "R5", "entry untouched", mem[l2a], l2e);
    end
    @(negedge clk);
    chk(done == 1'b0, "R9", "done single cycle", 32'(done), 32'h0);
    chk(req_ready == 1'b1, "R10", "ready after done", 32'(req_ready), 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 32'h1);
    chk(done == 1'b0, "R1", "reset done", 32'(done), 32'h0);
    chk(mem_req == 1'b0, "R1", "reset mem_req", 32'(mem_req), 32'h0);

    // sweep: every combination of the five low entry flags, access kind and privilege
    for (int f = 0; f < 32; f++) begin
      for (int w = 0; w < 2; w++) begin
        for (int u = 0; u < 2; u++) begin
          logic [31:0] va, l1e, l2e, base;
          va   = {10'(f * 7 + 3), 9'(f * 13 + u + 2 * w), 13'(f * 255 + w)};
          base = 32'h0040_3000 | 32'((f * 37) & 32'hFFF);
          l1e  = 32'h0080_0001 | (32'(f) << 11) | (32'(f) << 1);
          l2e  = {19'(32'h4_0000 ^ (f * 1237 + w * 3 + u)), 8'hA5, 5'(f)};
          run_case(va, w[0], u[0], base, l1e, l2e, (f + w + u) % 4);
        end
      end
    end

    // invalid first-level entries with all other bits set
    for (int k = 0; k < 8; k++) begin
      run_case({10'(k * 111), 9'(k * 50), 13'(k)}, k[0], k[1], 32'h0040_3000,
               32'h0080_07FE | (32'(k) << 11), 32'hFFFF_FFFF, k % 3);
    end

    // extreme indices and offsets
    run_case(32'hFFFF_FFFF, 1'b1, 1'b1, 32'h0040_3FFF, 32'h0080_07FF,
             32'h1234_E01F, 0);
    run_case(32'h0000_0000, 1'b0, 1'b0, 32'h0040_3000, 32'h0080_0001,
             32'hFFFF_E001, 2);
    run_case(32'h003F_E000, 1'b0, 1'b1, 32'h0040_3000, 32'h0080_0801,
             32'h0000_2011, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule